// File: doc/BRIEF.md
# DS3/E3 Alarm and Loss-of-Signal Monitor

This block sits behind a DS3/E3 framer and turns an already-aligned receive stream into four maintenance status bits: alarm indication signal (AIS), idle code, yellow (remote) alarm and loss of signal (LOS). The framer supplies one data bit per clock together with strobes that mark overhead positions (any overhead bit, X bits, C bits, the E3 A bit), a flag that is high throughout subframe 3, a strobe on the last bit of each M-frame, and framing-valid and parity-valid flags. A mode input selects DS3 or E3 rules.

AIS, idle and yellow are judged over a whole M-frame. The verdict is loaded into registered outputs on the clock that carries the frame's last bit, and it is held until the next such clock. Integration of these bits over time is left to a host. LOS is worked out separately on the raw line bits, before B3ZS/HDB3 decoding, one bit per clock. It sets on a long run of zeros and clears on a ones-density test whose threshold depends on the mode.

Top module: `dsx_alarm_mon`

## Requirements
- R1: All four outputs are 0 during reset. `ais_det`, `idle_det` and `yel_det` change only on a clock where `mf_end` is high. They then show the verdict for the bits from the previous `mf_end` clock (exclusive) through the current one (inclusive).
- R2: In DS3 mode `ais_det` is 1 only when all of these hold: `frm_ok` and `par_ok` were high on every clock of the frame; at least one X bit was seen and all X bits were equal; every C bit was 0; and every payload bit matched the AIS pattern.
- R3: The payload phase restarts after each overhead bit. The first payload bit after an overhead bit has phase 0, and the phase counts up by one on each later payload bit. The AIS pattern expects 1 at even phases and 0 at odd phases. The idle pattern expects 1 at phases 0 and 1 modulo 4 and 0 at phases 2 and 3.
- R4: In DS3 mode `idle_det` is 1 only when all of these hold: framing and parity were valid throughout the frame; the X bits were seen and all equal; every C bit taken while `sf3_flag` was high was 0; and every payload bit matched the idle pattern. C bits outside subframe 3 do not matter.
- R5: In DS3 mode `yel_det` is 1 only when at least one X bit was seen and every X bit of the frame was 0. X bits that disagree, or that are all 1, give 0.
- R6: In E3 mode `ais_det` is 1 only when every data bit of the frame, overhead included, was 1. `idle_det` is always 0. `yel_det` equals the value of the last A bit (the bit under `a_stb`) in the frame, and is 0 if the frame had no A bit.
- R7: `los_alarm` rises on the clock that samples the 175th consecutive 0 on `line_bit`. It stays 0 after 174 consecutive zeros.
- R8: While `los_alarm` is 1, the line bits are taken in back-to-back windows of 175 clocks. The first window starts on the clock after the alarm sets. The alarm clears at the end of a window whose ones count N meets N*100 > 33*175 in DS3 mode (N >= 58) or N*100 > 25*175 in E3 mode (N >= 44).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one stream bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| e3_mode | input | 1 | 1 selects E3 rules, 0 selects DS3 rules |
| rx_bit | input | 1 | Framed receive data bit |
| oh_stb | input | 1 | Current `rx_bit` is an overhead bit |
| x_stb | input | 1 | Current bit is an X bit (DS3) |
| c_stb | input | 1 | Current bit is a C bit (DS3) |
| a_stb | input | 1 | Current bit is the A bit (E3) |
| sf3_flag | input | 1 | High for all bits of subframe 3 (DS3) |
| mf_end | input | 1 | Current bit is the last of the M-frame |
| frm_ok | input | 1 | Framer reports valid alignment |
| par_ok | input | 1 | Parity check reports valid |
| line_bit | input | 1 | Raw line bit before zero-substitution decoding |
| ais_det | output | 1 | AIS seen in previous M-frame |
| idle_det | output | 1 | Idle code seen in previous M-frame |
| yel_det | output | 1 | Yellow alarm seen in previous M-frame |
| los_alarm | output | 1 | Loss of signal |

## Verification
Frames carrying a clean AIS payload are compared against frames that differ in one respect only: a single flipped payload bit, a set C bit, a single cycle without parity, or disagreeing X bits. Each variant shows that one rule on its own can veto AIS. The blocks in the idle frames are ten payload bits long, so an idle pattern that runs on across overhead bits falls out of step. A frame built that way tells a correct phase restart apart from a free-running one. A set C bit outside subframe 3 tells the subframe-3-only rule apart from an all-C rule, and E3 frames check the all-ones AIS, the A-bit yellow and the forced-zero idle. The LOS tests step each edge by one: a run of 174 zeros against one of 175, and windows with 57 against 58 ones in DS3 and 43 against 44 ones in E3.

// File: rtl/dsx_mon_pkg.sv
// Package: shared status record and constants for the DS3/E3 alarm monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package dsx_mon_pkg;

    // Per-frame verdict carried from the judging logic to the output register.
    typedef struct packed {
        logic ais;
        logic idle;
        logic yel;
    } dsx_stat_t;

    // Number of payload pattern lanes: lane 0 = 1010..., lane 1 = 1100...
    localparam int unsigned PAT_LANES = 2;

    // Percent scale used by the ones-density test.
    localparam int unsigned PCT_SCALE = 100;

endpackage

// File: rtl/dsx_oh_track.sv
// Module: dsx_oh_track
// Keeps running per-frame flags for overhead bits (X, C, A) and for
// framing/parity validity. The outputs are the flags with the current
// bit already folded in, so the top can load them on the mf_end clock.
// Assumes: the x/c/a strobes mark overhead bits only; mf_end marks the
// last bit of a frame, and the accumulators re-arm after that bit.
module dsx_oh_track (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic x_stb,
    input  logic c_stb,
    input  logic a_stb,
    input  logic sf3_flag,
    input  logic frm_ok,
    input  logic par_ok,
    input  logic mf_end,
    output logic fp_ok,
    output logic x_seen,
    output logic x_all0,
    output logic x_all1,
    output logic c_all0,
    output logic c3_all0,
    output logic a_seen,
    output logic a_one
);

    logic fp_q;
    logic xs_q;
    logic x0_q;
    logic x1_q;
    logic c_q;
    logic c3_q;
    logic as_q;
    logic a_q;

    // Fold the current bit into each running flag.
    always_comb begin
        fp_ok   = fp_q & frm_ok & par_ok;
        x_seen  = xs_q | x_stb;
        x_all0  = x0_q & ~(x_stb & rx_bit);
        x_all1  = x1_q & ~(x_stb & ~rx_bit);
        c_all0  = c_q & ~(c_stb & rx_bit);
        c3_all0 = c3_q & ~(c_stb & sf3_flag & rx_bit);
        a_seen  = as_q | a_stb;
        a_one   = a_stb ? rx_bit : a_q;
    end

    // Hold the running flags; re-arm them after the last bit of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || mf_end) begin
            fp_q <= 1'b1;
            xs_q <= 1'b0;
            x0_q <= 1'b1;
            x1_q <= 1'b1;
            c_q  <= 1'b1;
            c3_q <= 1'b1;
            as_q <= 1'b0;
            a_q  <= 1'b0;
        end else begin
            fp_q <= fp_ok;
            xs_q <= x_seen;
            x0_q <= x_all0;
            x1_q <= x_all1;
            c_q  <= c_all0;
            c3_q <= c3_all0;
            as_q <= a_seen;
            a_q  <= a_one;
        end
    end

endmodule

// File: rtl/dsx_pat_check.sv
// Module: dsx_pat_check
// Checks the payload against the repeating AIS and idle patterns, using
// a phase counter that restarts after each overhead bit. It also tracks
// whether every bit of the frame was 1 (the E3 AIS rule).
// Assumes: one bit per clock; overhead bits are excluded from the
// pattern check but included in the all-ones check.
module dsx_pat_check #(
    parameter int unsigned PH_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic oh_stb,
    input  logic mf_end,
    output logic ais_pat_ok,
    output logic idle_pat_ok,
    output logic all_ones
);

    import dsx_mon_pkg::*;

    logic [PH_W-1:0]      phase_q;
    logic [PAT_LANES-1:0] lane_ok_q;
    logic [PAT_LANES-1:0] lane_ok;
    logic                 ones_q;

    // Payload phase: cleared by an overhead bit, advanced by a payload bit.
    always_ff @(posedge clk) begin
        if (!rst_n || oh_stb) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // One lane per pattern; lane g expects 1 while phase bit g is 0.
    for (genvar g = 0; g < PAT_LANES; g++) begin : g_lane
        logic exp_bit;

        // Expected payload value for this lane at the current phase.
        always_comb begin
            exp_bit    = ~phase_q[g];
            lane_ok[g] = lane_ok_q[g] & (oh_stb | (rx_bit == exp_bit));
        end

        // Running match flag, re-armed after the last bit of a frame.
        always_ff @(posedge clk) begin
            if (!rst_n || mf_end) begin
                lane_ok_q[g] <= 1'b1;
            end else begin
                lane_ok_q[g] <= lane_ok[g];
            end
        end
    end

    // Every bit of the frame so far is 1.
    always_ff @(posedge clk) begin
        if (!rst_n || mf_end) begin
            ones_q <= 1'b1;
        end else begin
            ones_q <= all_ones;
        end
    end

    // Results with the current bit included.
    always_comb begin
        ais_pat_ok  = lane_ok[0];
        idle_pat_ok = lane_ok[1];
        all_ones    = ones_q & rx_bit;
    end

endmodule

// File: rtl/dsx_los_det.sv
// Module: dsx_los_det
// Loss-of-signal detector on raw line bits. The alarm sets on a run of
// RUN_LEN zeros. It clears at the end of a WIN_LEN-clock window whose
// ones density is above the percentage chosen by the mode.
// Assumes: one line bit per clock; windows run back to back and the
// first one starts on the clock after the alarm sets.
module dsx_los_det #(
    parameter int unsigned RUN_LEN = 175,
    parameter int unsigned WIN_LEN = 175,
    parameter int unsigned PCT_DS3 = 33,
    parameter int unsigned PCT_E3  = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic e3_mode,
    input  logic line_bit,
    output logic los
);

    import dsx_mon_pkg::*;

    localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);
    localparam int unsigned WIN_W = $clog2(WIN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

    logic [RUN_W-1:0] zrun_q;
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] ones_q;
    logic [WIN_W-1:0] ones_nx;
    logic             set_hit;
    logic             win_end;
    logic             dens_ok;
    int unsigned      pct;

    // Run-start, window-end and density decisions for this clock.
    always_comb begin
        ones_nx = ones_q + {{(WIN_W-1){1'b0}}, line_bit};
        pct     = e3_mode ? PCT_E3 : PCT_DS3;
        set_hit = !los && !line_bit && (zrun_q >= RUN_LAST);
        win_end = los && (win_q == WIN_LAST);
        dens_ok = (32'(ones_nx) * PCT_SCALE) > (pct * WIN_LEN);
    end

    // Consecutive-zero counter, saturating at RUN_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n || line_bit) begin
            zrun_q <= '0;
        end else if (zrun_q < RUN_W'(RUN_LEN)) begin
            zrun_q <= zrun_q + 1'b1;
        end
    end

    // Window position and ones count, active only while the alarm is up.
    always_ff @(posedge clk) begin
        if (!rst_n || !los || win_end) begin
            win_q  <= '0;
            ones_q <= '0;
        end else begin
            win_q  <= win_q + 1'b1;
            ones_q <= ones_nx;
        end
    end

    // Alarm flag: set on the long zero run, clear on a dense window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            los <= 1'b0;
        end else if (set_hit) begin
            los <= 1'b1;
        end else if (win_end && dens_ok) begin
            los <= 1'b0;
        end
    end

endmodule

// File: rtl/dsx_alarm_mon.sv
// Module: dsx_alarm_mon (top)
// DS3/E3 maintenance status monitor. It joins the overhead tracker and
// the payload pattern checker into a per-frame verdict, registers that
// verdict on the mf_end clock, and runs the loss-of-signal detector
// on its own.
// Assumes: the stream is aligned by an upstream framer that supplies
// the strobes; e3_mode is sampled on the mf_end clock for the verdict.
module dsx_alarm_mon #(
    parameter int unsigned RUN_LEN = 175,
    parameter int unsigned WIN_LEN = 175,
    parameter int unsigned PCT_DS3 = 33,
    parameter int unsigned PCT_E3  = 25,
    parameter int unsigned PH_W    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic e3_mode,
    input  logic rx_bit,
    input  logic oh_stb,
    input  logic x_stb,
    input  logic c_stb,
    input  logic a_stb,
    input  logic sf3_flag,
    input  logic mf_end,
    input  logic frm_ok,
    input  logic par_ok,
    input  logic line_bit,
    output logic ais_det,
    output logic idle_det,
    output logic yel_det,
    output logic los_alarm
);

    import dsx_mon_pkg::*;

    logic fp_ok;
    logic x_seen;
    logic x_all0;
    logic x_all1;
    logic c_all0;
    logic c3_all0;
    logic a_seen;
    logic a_one;
    logic ais_pat_ok;
    logic idle_pat_ok;
    logic all_ones;
    logic x_agree;
    dsx_stat_t verdict;
    dsx_stat_t stat_q;

    dsx_oh_track u_oh (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_bit   (rx_bit),
        .x_stb    (x_stb),
        .c_stb    (c_stb),
        .a_stb    (a_stb),
        .sf3_flag (sf3_flag),
        .frm_ok   (frm_ok),
        .par_ok   (par_ok),
        .mf_end   (mf_end),
        .fp_ok    (fp_ok),
        .x_seen   (x_seen),
        .x_all0   (x_all0),
        .x_all1   (x_all1),
        .c_all0   (c_all0),
        .c3_all0  (c3_all0),
        .a_seen   (a_seen),
        .a_one    (a_one)
    );

    dsx_pat_check #(.PH_W(PH_W)) u_pat (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_bit      (rx_bit),
        .oh_stb      (oh_stb),
        .mf_end      (mf_end),
        .ais_pat_ok  (ais_pat_ok),
        .idle_pat_ok (idle_pat_ok),
        .all_ones    (all_ones)
    );

    dsx_los_det #(
        .RUN_LEN (RUN_LEN),
        .WIN_LEN (WIN_LEN),
        .PCT_DS3 (PCT_DS3),
        .PCT_E3  (PCT_E3)
    ) u_los (
        .clk      (clk),
        .rst_n    (rst_n),
        .e3_mode  (e3_mode),
        .line_bit (line_bit),
        .los      (los_alarm)
    );

    // Frame verdict under the rules of the selected mode.
    always_comb begin
        x_agree = x_seen & (x_all0 | x_all1);
        if (e3_mode) begin
            verdict.ais  = all_ones;
            verdict.idle = 1'b0;
            verdict.yel  = a_seen & a_one;
        end else begin
            verdict.ais  = fp_ok & x_agree & c_all0 & ais_pat_ok;
            verdict.idle = fp_ok & x_agree & c3_all0 & idle_pat_ok;
            verdict.yel  = x_seen & x_all0;
        end
    end

    // Status register, loaded only on the last bit of an M-frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (mf_end) begin
            stat_q <= verdict;
        end
    end

    assign ais_det  = stat_q.ais;
    assign idle_det = stat_q.idle;
    assign yel_det  = stat_q.yel;

endmodule

// File: rtl/dsx_alarm_mon_chk.sv
// Module: dsx_alarm_mon_chk
// Assertion checker for dsx_alarm_mon, attached by bind. It keeps its
// own zero-run counter on the line input so that the loss-of-signal
// timing is checked without reaching into the design.
module dsx_alarm_mon_chk #(
    parameter int unsigned RUN_LEN = 175
) (
    input logic clk,
    input logic rst_n,
    input logic e3_mode,
    input logic mf_end,
    input logic line_bit,
    input logic ais_det,
    input logic idle_det,
    input logic yel_det,
    input logic los_alarm
);

    localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);

    logic [RUN_W-1:0] zrun_c;

    // Independent count of consecutive zeros, saturating at RUN_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n || line_bit) begin
            zrun_c <= '0;
        end else if (zrun_c < RUN_W'(RUN_LEN)) begin
            zrun_c <= zrun_c + 1'b1;
        end
    end

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_end |=> $stable({ais_det, idle_det, yel_det})); // R1

    AST_E3_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_end && e3_mode) |=> !idle_det); // R6

    AST_LOS_ON_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (zrun_c >= RUN_W'(RUN_LEN)) |-> los_alarm); // R7

    AST_LOS_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_alarm) |-> (zrun_c >= RUN_W'(RUN_LEN))); // R7

endmodule

bind dsx_alarm_mon dsx_alarm_mon_chk #(.RUN_LEN(RUN_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .e3_mode   (e3_mode),
    .mf_end    (mf_end),
    .line_bit  (line_bit),
    .ais_det   (ais_det),
    .idle_det  (idle_det),
    .yel_det   (yel_det),
    .los_alarm (los_alarm)
);

// File: tb/test_dsx_alarm_mon.sv
// Directed bench for dsx_alarm_mon. A reduced M-frame of 7 subframes x
// 8 blocks x (1 overhead + 10 payload bits) is built here. X bits sit in
// block 0 of subframes 0 and 1, C bits in blocks 2, 4 and 6, and the A
// bit in block 1 of subframe 0.
module test_dsx_alarm_mon;

    localparam int PL   = 10;
    localparam int SUBF = 7;
    localparam int BLK  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic e3_mode = 1'b0;
    logic rx_bit = 1'b0;
    logic oh_stb = 1'b0;
    logic x_stb = 1'b0;
    logic c_stb = 1'b0;
    logic a_stb = 1'b0;
    logic sf3_flag = 1'b0;
    logic mf_end = 1'b0;
    logic frm_ok = 1'b1;
    logic par_ok = 1'b1;
    logic line_bit = 1'b1;
    logic ais_det;
    logic idle_det;
    logic yel_det;
    logic los_alarm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dsx_alarm_mon i_dsx_alarm_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .e3_mode   (e3_mode),
        .rx_bit    (rx_bit),
        .oh_stb    (oh_stb),
        .x_stb     (x_stb),
        .c_stb     (c_stb),
        .a_stb     (a_stb),
        .sf3_flag  (sf3_flag),
        .mf_end    (mf_end),
        .frm_ok    (frm_ok),
        .par_ok    (par_ok),
        .line_bit  (line_bit),
        .ais_det   (ais_det),
        .idle_det  (idle_det),
        .yel_det   (yel_det),
        .los_alarm (los_alarm)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // kind: 0 AIS pattern, 1 idle pattern, 2 all ones, 3 idle pattern without restart.
    task automatic send_frame(input logic e3, input int kind, input logic x0, input logic x1,
                              input logic c_oth, input logic c_s3, input logic a_val,
                              input int err_at, input int fv_at, input int pv_at);
        int   idx;
        int   pl_idx;
        int   ph;
        logic b;
        idx = 0;
        pl_idx = 0;
        for (int sub = 0; sub < SUBF; sub++) begin
            for (int blk = 0; blk < BLK; blk++) begin
                for (int pos = 0; pos <= PL; pos++) begin
                    @(negedge clk);
                    e3_mode  = e3;
                    oh_stb   = (pos == 0);
                    x_stb    = 1'b0;
                    c_stb    = 1'b0;
                    a_stb    = 1'b0;
                    sf3_flag = (sub == 2);
                    line_bit = 1'b1;
                    if (pos == 0) begin
                        b = 1'b1;
                        if (blk == 0 && sub < 2) begin
                            x_stb = 1'b1;
                            b = (sub == 0) ? x0 : x1;
                        end
                        if (blk == 2 || blk == 4 || blk == 6) begin
                            c_stb = 1'b1;
                            b = (sub == 2) ? c_s3 : c_oth;
                        end
                        if (sub == 0 && blk == 1) begin
                            a_stb = 1'b1;
                            b = a_val;
                        end
                    end else begin
                        ph = (kind == 3) ? pl_idx : pos - 1;
                        case (kind)
                            0:       b = ((ph % 2) == 0);
                            2:       b = 1'b1;
                            default: b = ((ph % 4) < 2);
                        endcase
                        pl_idx++;
                    end
                    if (idx == err_at) b = ~b;
                    frm_ok = (idx != fv_at);
                    par_ok = (idx != pv_at);
                    mf_end = (sub == SUBF-1) && (blk == BLK-1) && (pos == PL);
                    rx_bit = b;
                    idx++;
                end
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic drive_line(input logic e3, input logic val, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            e3_mode  = e3;
            mf_end   = 1'b0;
            oh_stb   = 1'b0;
            x_stb    = 1'b0;
            c_stb    = 1'b0;
            a_stb    = 1'b0;
            line_bit = val;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset ais", ais_det, 1'b0);
        chk("R1 reset idle", idle_det, 1'b0);
        chk("R1 reset yel", yel_det, 1'b0);
        chk("R1 reset los", los_alarm, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        send_frame(1'b0, 0, 1, 1, 0, 0, 1, -1, -1, -1);
    endtask

    task automatic t_ds3_ais();
        send_frame(1'b0, 0, 1, 1, 0, 0, 1, -1, -1, -1);
        chk("R2 clean AIS ais", ais_det, 1'b1);
        chk("R4 clean AIS idle", idle_det, 1'b0);
        chk("R5 X=11 yel", yel_det, 1'b0);
        send_frame(1'b0, 0, 1, 1, 0, 0, 1, 200, -1, -1);
        chk("R2 one payload error", ais_det, 1'b0);
        send_frame(1'b0, 0, 1, 1, 1, 0, 1, -1, -1, -1);
        chk("R2 C bit set", ais_det, 1'b0);
        send_frame(1'b0, 0, 1, 1, 0, 0, 1, -1, -1, 300);
        chk("R2 parity drop", ais_det, 1'b0);
        send_frame(1'b0, 0, 1, 1, 0, 0, 1, -1, 400, -1);
        chk("R2 framing drop", ais_det, 1'b0);
        send_frame(1'b0, 0, 1, 0, 0, 0, 1, -1, -1, -1);
        chk("R2 X disagree ais", ais_det, 1'b0);
        chk("R5 X disagree yel", yel_det, 1'b0);
    endtask

    task automatic t_ds3_idle();
        send_frame(1'b0, 1, 0, 0, 1, 0, 1, -1, -1, -1);
        chk("R4 idle with C set outside sf3", idle_det, 1'b1);
        chk("R2 idle frame ais", ais_det, 1'b0);
        chk("R5 X=00 yel", yel_det, 1'b1);
        send_frame(1'b0, 1, 0, 0, 0, 1, 1, -1, -1, -1);
        chk("R4 sf3 C set", idle_det, 1'b0);
        send_frame(1'b0, 3, 0, 0, 0, 0, 1, -1, -1, -1);
        chk("R3 pattern without restart", idle_det, 1'b0);
    endtask

    task automatic t_e3();
        send_frame(1'b1, 2, 1, 1, 1, 1, 1, -1, -1, -1);
        chk("R6 all ones ais", ais_det, 1'b1);
        chk("R6 A=1 yel", yel_det, 1'b1);
        chk("R6 idle forced 0", idle_det, 1'b0);
        send_frame(1'b1, 2, 1, 1, 1, 1, 0, -1, -1, -1);
        chk("R6 single zero ais", ais_det, 1'b0);
        chk("R6 A=0 yel", yel_det, 1'b0);
        send_frame(1'b1, 1, 0, 0, 0, 0, 0, -1, -1, -1);
        chk("R6 idle pattern in E3", idle_det, 1'b0);
        chk("R6 X=00 ignored yel", yel_det, 1'b0);
    endtask

    task automatic t_los();
        drive_line(1'b0, 1'b1, 5);
        drive_line(1'b0, 1'b0, 174);
        chk("R7 174 zeros", los_alarm, 1'b0);
        drive_line(1'b0, 1'b0, 1);
        chk("R7 175 zeros", los_alarm, 1'b1);
        drive_line(1'b0, 1'b1, 57);
        drive_line(1'b0, 1'b0, 118);
        chk("R8 DS3 57 ones", los_alarm, 1'b1);
        drive_line(1'b0, 1'b1, 58);
        drive_line(1'b0, 1'b0, 117);
        chk("R8 DS3 58 ones", los_alarm, 1'b0);
        drive_line(1'b1, 1'b1, 5);
        drive_line(1'b1, 1'b0, 174);
        chk("R7 E3 174 zeros", los_alarm, 1'b0);
        drive_line(1'b1, 1'b0, 1);
        chk("R7 E3 175 zeros", los_alarm, 1'b1);
        drive_line(1'b1, 1'b1, 43);
        drive_line(1'b1, 1'b0, 132);
        chk("R8 E3 43 ones", los_alarm, 1'b1);
        drive_line(1'b1, 1'b1, 44);
        drive_line(1'b1, 1'b0, 131);
        chk("R8 E3 44 ones", los_alarm, 1'b0);
    endtask

    initial begin
        t_reset();
        t_ds3_ais();
        t_ds3_idle();
        t_e3();
        t_los();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule